// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Controller

This block is the hazard controller of an in-order five-stage integer pipeline (fetch, decode, execute, memory, write-back). It looks at register indices captured in the pipeline registers and decides three things every cycle. First, where each ALU source operand in EX is taken from. Second, whether the front of the pipeline must wait one cycle behind a load. Third, whether the two younger instructions behind a taken branch or jump must be thrown away.

Each EX operand has its own three-way source choice:

- the register-file value read in decode;
- the result held in the EX/MEM register (the newer producer);
- the value held in the MEM/WB register (the older producer).

When a load in EX writes a register that the decoding instruction actually reads, the controller holds the PC and the IF/ID register for a single cycle and injects a bubble into EX. After that cycle the loaded value reaches the consumer over the MEM/WB path.

A branch or jump that resolves as taken in EX has two younger instructions behind it. The controller clears the fetched instruction in IF/ID and turns the decoding instruction into a bubble in EX, while the PC loads the target. A taken redirect overrides a simultaneous load-use stall.

Top module: `hazard_ctrl`

## Requirements
- R1: An EX source index that equals `mem_rd` while `mem_we` is 1 selects the EX/MEM result, select code 2'b01, on that operand's select output (`fwd_sel_a` for `ex_rs1`, `fwd_sel_b` for `ex_rs2`), independently per operand.
- R2: An EX source index that equals `wb_rd` while `wb_we` is 1, with no EX/MEM match, selects the MEM/WB value, select code 2'b10.
- R3: When both EX/MEM and MEM/WB match the same source index, the EX/MEM result (2'b01) wins.
- R4: With no match, or with a matching stage whose write enable is 0, the select is the register-file value, code 2'b00.
- R5: With ZERO_REG=1, source index 0 never selects a forwarding path, and a load to index 0 never raises a stall.
- R6: A load-use hazard exists when `ex_is_load` is 1 and `ex_rd` equals a used ID source (`id_rs1` with `id_rs1_used`, `id_rs2` with `id_rs2_used`). It drives `pc_hold`=1, `ifid_hold`=1, `ex_bubble`=1 and `ifid_flush`=0.
- R7: An ID source whose use flag is 0 never causes a stall, whatever its index.
- R8: A stall lasts one cycle only. In the cycle after a stall cycle, `pc_hold` and `ifid_hold` are 0 even if the hazard condition is still present. The next cycle may stall again.
- R9: `ex_taken`=1 drives `ifid_flush`=1 and `ex_bubble`=1 with `pc_hold`=0 and `ifid_hold`=0, cancelling both younger instructions.
- R10: When `ex_taken` and a load-use hazard coincide, the outputs are those of R9.
- R11: While `rst_n` is 0 with idle inputs, all outputs are 0. The first hazard after reset release stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the stall-limit flag |
| id_rs1 | input | IDX_W | First source index of the ID instruction |
| id_rs2 | input | IDX_W | Second source index of the ID instruction |
| id_rs1_used | input | 1 | ID instruction reads its first source |
| id_rs2_used | input | 1 | ID instruction reads its second source |
| ex_rs1 | input | IDX_W | First source index of the EX instruction |
| ex_rs2 | input | IDX_W | Second source index of the EX instruction |
| ex_rd | input | IDX_W | Destination index of the EX instruction |
| ex_is_load | input | 1 | EX instruction is a load |
| ex_taken | input | 1 | Branch or jump in EX resolved taken |
| mem_rd | input | IDX_W | Destination index in EX/MEM |
| mem_we | input | 1 | Register write enable in EX/MEM |
| wb_rd | input | IDX_W | Destination index in MEM/WB |
| wb_we | input | 1 | Register write enable in MEM/WB |
| fwd_sel_a | output | 2 | Operand 1 source select: 00 register file, 01 EX/MEM, 10 MEM/WB |
| fwd_sel_b | output | 2 | Operand 2 source select, same coding |
| pc_hold | output | 1 | Hold the PC this cycle |
| ifid_hold | output | 1 | Hold the IF/ID register this cycle |
| ex_bubble | output | 1 | Load a NOP into ID/EX |
| ifid_flush | output | 1 | Clear IF/ID to a NOP |

## Verification
The bench builds the controller with IDX_W=5 and ZERO_REG=1, which is the 32-entry register file with a hard-wired zero register. This reaches index 0, where forwarding and stalls must stay off, and index 31, the top of the range, on both the forwarding and load-use paths. Directed scenarios cover each operand alone and both operands together, one and both producers matching, write enables low, unused sources, a persistent hazard that must stall only every other cycle, and a taken redirect colliding with a stall.

// File: rtl/hz_pkg.sv
package hz_pkg;
   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SRC_REGFILE = 2'b00,
      SRC_NEAR    = 2'b01,
      SRC_FAR     = 2'b10
   } src_sel_e;
endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
   import hz_pkg::*;
#(
   parameter int IDX_W    = 5,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic [IDX_W-1:0] src_idx,
   input  logic [IDX_W-1:0] near_rd,
   input  logic             near_we,
   input  logic [IDX_W-1:0] far_rd,
   input  logic             far_we,
   output src_sel_e         sel
);
   logic src_live;
   logic near_hit;
   logic far_hit;

   generate
      if (ZERO_REG) begin : g_zero
         assign src_live = (src_idx != '0);
      end else begin : g_nozero
         assign src_live = 1'b1;
      end
   endgenerate

   assign near_hit = near_we && (near_rd == src_idx) && src_live;
   assign far_hit  = far_we  && (far_rd  == src_idx) && src_live;

   always_comb begin
      if (near_hit)     sel = SRC_NEAR;
      else if (far_hit) sel = SRC_FAR;
      else              sel = SRC_REGFILE;
   end
endmodule

// File: rtl/hz_loaduse_det.sv
module hz_loaduse_det #(
   parameter int IDX_W    = 5,
   parameter int NUM_SRC  = 2,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic [NUM_SRC-1:0][IDX_W-1:0] id_src,
   input  logic [NUM_SRC-1:0]            id_used,
   input  logic [IDX_W-1:0]              ex_rd,
   input  logic                          ex_is_load,
   output logic                          hazard
);
   logic             dst_live;
   logic [NUM_SRC-1:0] hit;

   generate
      if (ZERO_REG) begin : g_zero
         assign dst_live = (ex_rd != '0);
      end else begin : g_nozero
         assign dst_live = 1'b1;
      end

      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         assign hit[s] = id_used[s] && (id_src[s] == ex_rd);
      end
   endgenerate

   assign hazard = ex_is_load && dst_live && (|hit);
endmodule

// File: rtl/hz_seq_ctrl.sv
module hz_seq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic hazard,
   input  logic taken,
   output logic pc_hold,
   output logic ifid_hold,
   output logic ex_bubble,
   output logic ifid_flush
);
   logic stalled_q;
   logic stall_now;

   assign stall_now  = hazard && !stalled_q && !taken;
   assign pc_hold    = stall_now;
   assign ifid_hold  = stall_now;
   assign ex_bubble  = stall_now || taken;
   assign ifid_flush = taken;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stalled_q <= 1'b0;
      else        stalled_q <= stall_now;
   end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
   import hz_pkg::*;
#(
   parameter int IDX_W    = 5,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] id_rs1,
   input  logic [IDX_W-1:0] id_rs2,
   input  logic             id_rs1_used,
   input  logic             id_rs2_used,
   input  logic [IDX_W-1:0] ex_rs1,
   input  logic [IDX_W-1:0] ex_rs2,
   input  logic [IDX_W-1:0] ex_rd,
   input  logic             ex_is_load,
   input  logic             ex_taken,
   input  logic [IDX_W-1:0] mem_rd,
   input  logic             mem_we,
   input  logic [IDX_W-1:0] wb_rd,
   input  logic             wb_we,
   output logic [SEL_W-1:0] fwd_sel_a,
   output logic [SEL_W-1:0] fwd_sel_b,
   output logic             pc_hold,
   output logic             ifid_hold,
   output logic             ex_bubble,
   output logic             ifid_flush
);
   localparam int NUM_SRC = 2;

   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_width
         $error("hazard_ctrl: IDX_W must be within 1..8");
      end
   endgenerate

   logic [NUM_SRC-1:0][IDX_W-1:0] ex_src;
   logic [NUM_SRC-1:0][IDX_W-1:0] id_src;
   logic [NUM_SRC-1:0]            id_used;
   src_sel_e                      sel [NUM_SRC];
   logic                          hazard;

   assign ex_src  = {ex_rs2, ex_rs1};
   assign id_src  = {id_rs2, id_rs1};
   assign id_used = {id_rs2_used, id_rs1_used};

   generate
      for (genvar o = 0; o < NUM_SRC; o++) begin : g_opnd
         hz_fwd_unit #(
            .IDX_W    (IDX_W),
            .ZERO_REG (ZERO_REG)
         ) i_fwd (
            .src_idx (ex_src[o]),
            .near_rd (mem_rd),
            .near_we (mem_we),
            .far_rd  (wb_rd),
            .far_we  (wb_we),
            .sel     (sel[o])
         );
      end
   endgenerate

   assign fwd_sel_a = sel[0];
   assign fwd_sel_b = sel[1];

   hz_loaduse_det #(
      .IDX_W    (IDX_W),
      .NUM_SRC  (NUM_SRC),
      .ZERO_REG (ZERO_REG)
   ) i_lu (
      .id_src     (id_src),
      .id_used    (id_used),
      .ex_rd      (ex_rd),
      .ex_is_load (ex_is_load),
      .hazard     (hazard)
   );

   hz_seq_ctrl i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .hazard     (hazard),
      .taken      (ex_taken),
      .pc_hold    (pc_hold),
      .ifid_hold  (ifid_hold),
      .ex_bubble  (ex_bubble),
      .ifid_flush (ifid_flush)
   );
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
   parameter int IDX_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] ex_rs1,
   input logic [IDX_W-1:0] mem_rd,
   input logic             mem_we,
   input logic [IDX_W-1:0] wb_rd,
   input logic             wb_we,
   input logic             ex_taken,
   input logic [1:0]       fwd_sel_a,
   input logic             pc_hold,
   input logic             ifid_hold,
   input logic             ex_bubble,
   input logic             ifid_flush
);
   // R3
   near_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && wb_we && mem_rd == ex_rs1 && wb_rd == ex_rs1 && ex_rs1 != '0)
      |-> fwd_sel_a == 2'b01);

   // R5
   zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_rs1 == '0) |-> fwd_sel_a == 2'b00);

   // R4
   no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we && !wb_we) |-> fwd_sel_a == 2'b00);

   // R8
   single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold |=> !pc_hold);

   // R6
   stall_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold |-> (ifid_hold && ex_bubble && !ifid_flush));

   // R9
   redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ex_taken |-> (ifid_flush && ex_bubble && !pc_hold && !ifid_hold));
endmodule

bind hazard_ctrl hz_ctrl_chk #(.IDX_W(IDX_W)) i_hz_ctrl_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ex_rs1     (ex_rs1),
   .mem_rd     (mem_rd),
   .mem_we     (mem_we),
   .wb_rd      (wb_rd),
   .wb_we      (wb_we),
   .ex_taken   (ex_taken),
   .fwd_sel_a  (fwd_sel_a),
   .pc_hold    (pc_hold),
   .ifid_hold  (ifid_hold),
   .ex_bubble  (ex_bubble),
   .ifid_flush (ifid_flush)
);

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;
   localparam int IDX_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [IDX_W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
   logic             id_rs1_used, id_rs2_used, ex_is_load, ex_taken, mem_we, wb_we;
   logic [1:0]       fwd_sel_a, fwd_sel_b;
   logic             pc_hold, ifid_hold, ex_bubble, ifid_flush;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   hazard_ctrl #(.IDX_W(IDX_W), .ZERO_REG(1'b1)) i_hazard_ctrl (
      .clk(clk), .rst_n(rst_n),
      .id_rs1(id_rs1), .id_rs2(id_rs2),
      .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
      .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
      .ex_is_load(ex_is_load), .ex_taken(ex_taken),
      .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
      .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
      .pc_hold(pc_hold), .ifid_hold(ifid_hold),
      .ex_bubble(ex_bubble), .ifid_flush(ifid_flush)
   );

   // packed view: {sel_a, sel_b, pc_hold, ifid_hold, ex_bubble, ifid_flush}
   task automatic expect_out(input string req, input logic [1:0] ea,
                             input logic [1:0] eb, input logic [3:0] ectl);
      logic [7:0] act, exp;
      act = {fwd_sel_a, fwd_sel_b, pc_hold, ifid_hold, ex_bubble, ifid_flush};
      exp = {ea, eb, ectl};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic idle();
      id_rs1 = '0; id_rs2 = '0; id_rs1_used = 1'b0; id_rs2_used = 1'b0;
      ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; ex_is_load = 1'b0; ex_taken = 1'b0;
      mem_rd = '0; mem_we = 1'b0; wb_rd = '0; wb_we = 1'b0;
   endtask

   // drive at the falling edge, observe 1 ns later
   task automatic settle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      idle();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      settle(); #1;
      expect_out("R11 reset idle", 2'b00, 2'b00, 4'b0000);
      rst_n = 1'b1;
      settle();
      ex_is_load = 1'b1; ex_rd = 5'd7; id_rs1 = 5'd7; id_rs1_used = 1'b1;
      #1 expect_out("R11 first hazard after reset", 2'b00, 2'b00, 4'b1110);
      settle(); idle(); @(posedge clk); settle(); #1;
   endtask

   task automatic t_forward();
      settle(); idle();
      ex_rs1 = 5'd4; mem_rd = 5'd4; mem_we = 1'b1;
      #1 expect_out("R1 near on operand 1", 2'b01, 2'b00, 4'b0000);
      ex_rs1 = 5'd9; ex_rs2 = 5'd4;
      #1 expect_out("R1 near on operand 2", 2'b00, 2'b01, 4'b0000);
      idle(); ex_rs1 = 5'd31; ex_rs2 = 5'd12; wb_rd = 5'd31; wb_we = 1'b1;
      mem_rd = 5'd12; mem_we = 1'b1;
      #1 expect_out("R2 far op1 with near op2", 2'b10, 2'b01, 4'b0000);
      idle(); ex_rs1 = 5'd6; ex_rs2 = 5'd6; mem_rd = 5'd6; wb_rd = 5'd6;
      mem_we = 1'b1; wb_we = 1'b1;
      #1 expect_out("R3 near wins over far", 2'b01, 2'b01, 4'b0000);
      mem_we = 1'b0;
      #1 expect_out("R4 near disabled falls to far", 2'b10, 2'b10, 4'b0000);
      wb_we = 1'b0;
      #1 expect_out("R4 both disabled", 2'b00, 2'b00, 4'b0000);
      mem_we = 1'b1; wb_we = 1'b1; mem_rd = 5'd7; wb_rd = 5'd8;
      #1 expect_out("R4 no index match", 2'b00, 2'b00, 4'b0000);
   endtask

   task automatic t_zero();
      settle(); idle();
      mem_we = 1'b1; wb_we = 1'b1;
      #1 expect_out("R5 x0 not forwarded", 2'b00, 2'b00, 4'b0000);
      ex_is_load = 1'b1; id_rs1_used = 1'b1; id_rs2_used = 1'b1;
      #1 expect_out("R5 load to x0 no stall", 2'b00, 2'b00, 4'b0000);
   endtask

   task automatic t_loaduse();
      settle(); idle();
      ex_is_load = 1'b1; ex_rd = 5'd31; id_rs2 = 5'd31; id_rs2_used = 1'b1;
      id_rs1 = 5'd3; id_rs1_used = 1'b1;
      #1 expect_out("R6 load-use on rs2", 2'b00, 2'b00, 4'b1110);
      settle(); idle(); @(posedge clk); settle();
      ex_is_load = 1'b1; ex_rd = 5'd31; id_rs2 = 5'd31; id_rs2_used = 1'b0;
      id_rs1 = 5'd31; id_rs1_used = 1'b0;
      #1 expect_out("R7 unused sources ignored", 2'b00, 2'b00, 4'b0000);
      ex_is_load = 1'b0; id_rs1_used = 1'b1;
      #1 expect_out("R6 non-load no stall", 2'b00, 2'b00, 4'b0000);
   endtask

   task automatic t_one_cycle();
      settle(); idle(); @(posedge clk); settle();
      ex_is_load = 1'b1; ex_rd = 5'd10; id_rs1 = 5'd10; id_rs1_used = 1'b1;
      #1 expect_out("R8 first stall cycle", 2'b00, 2'b00, 4'b1110);
      settle(); #1;
      expect_out("R8 no second stall", 2'b00, 2'b00, 4'b0000);
      settle(); #1;
      expect_out("R8 stall allowed again", 2'b00, 2'b00, 4'b1110);
      settle(); idle(); @(posedge clk); settle(); #1;
   endtask

   task automatic t_redirect();
      settle(); idle();
      ex_taken = 1'b1;
      #1 expect_out("R9 taken flush", 2'b00, 2'b00, 4'b0011);
      ex_is_load = 1'b1; ex_rd = 5'd5; id_rs1 = 5'd5; id_rs1_used = 1'b1;
      #1 expect_out("R10 flush beats stall", 2'b00, 2'b00, 4'b0011);
      settle(); ex_taken = 1'b0;
      #1 expect_out("R10 stall after flush cycle", 2'b00, 2'b00, 4'b1110);
      settle(); idle(); @(posedge clk); settle(); #1;
   endtask

   initial begin
      idle();
      t_reset();
      t_forward();
      t_zero();
      t_loaduse();
      t_one_cycle();
      t_redirect();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule